// File: doc/BRIEF.md
# Transmit Frame Validator and Launcher

This block sends one Ethernet frame that software has already laid out in a 2048-byte transmit buffer as a full wire image: preamble, start delimiter, body and a trailing four-byte check sequence. Software starts a send by writing a nonzero byte count to the launch-count register. The block then checks the length and the eight leading bytes of the buffer. A frame that passes is streamed out one byte per cycle. The stream starts after the eight header bytes and stops before the four trailing bytes.

Every attempt ends with a one-cycle completion pulse, whether the frame was sent or rejected. After a successful send the count register reads zero. After a rejection it still holds the value software wrote, so software can tell the two outcomes apart. The buffer is read through a simple port with one cycle of read latency.

The output is a valid/ready byte stream. A byte transfers on a rising edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the byte and its last flag hold still. `tx_ready` may drop at any time without losing or repeating a byte. Buffer reads are issued only when the two-entry output stage can take the returning byte.

Top module: `tx_frame_launcher`

## Requirements
- R1: A write with nonzero data while `busy` is low starts an attempt, and `busy` reads 1 on the next cycle. A write of zero while idle only stores zero in the count register, with no attempt and no pulse.
- R2: A count below 64 is rejected: no byte is streamed and `done_irq` pulses.
- R3: A count above 1530 is rejected: no byte is streamed and `done_irq` pulses.
- R4: The frame is rejected, with no byte streamed, unless buffer bytes 0 to 6 all equal 0x55 and byte 7 equals 0xD5.
- R5: An accepted frame streams buffer bytes at addresses 8 up to count-5 in ascending order, count-12 bytes in all. No byte is streamed while `busy` is low.
- R6: `tx_last` is high with the final streamed byte and low with every other byte.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged on the next cycle. No byte is lost or duplicated under any `tx_ready` pattern.
- R8: While `done_irq` is high, `count_q` reads 0 after a successful send. After a rejection it reads the value that was written.
- R9: `done_irq` is high for exactly one cycle per attempt, at its end, after the last byte has transferred.
- R10: While `busy` is high, writes to the count register are ignored: the count is not changed and no further attempt is made.
- R11: After reset, `busy`, `tx_valid` and `done_irq` are 0 and `count_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_en | input | 1 | Write strobe for the launch-count register |
| cnt_wr_data | input | 16 | Byte count written (whole wire image) |
| count_q | output | 16 | Current value of the launch-count register |
| busy | output | 1 | High from the cycle after a start until the end of the completion pulse |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | 11 | Buffer byte address |
| buf_rd_data | input | 8 | Buffer byte, valid the cycle after the request |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Marks the final byte of the frame |
| done_irq | output | 1 | One-cycle completion pulse per attempt |

## Verification
The assertions assume that `buf_rd_data` carries the byte at the address requested on the previous cycle. They also assume that `tx_ready` and the write port are driven cleanly between clock edges. The bench models the buffer as a registered memory and drives every input on the falling edge, so both assumptions hold. It loads frame images before each launch and never changes the buffer during an attempt. It varies `tx_ready` with fixed stall patterns, so the hold and no-loss rules are tested under back-pressure.

// File: rtl/txl_pkg.sv
package txl_pkg;
  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SEND,
    ST_DONE
  } txl_state_e;
endpackage

// File: rtl/txl_count_reg.sv
module txl_count_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             busy,
  input  logic             clr,
  output logic [CNT_W-1:0] count_q,
  output logic             start
);
  logic accept;

  // Writes land only while idle; a nonzero value also launches an attempt.
  assign accept = wr_en && !busy;
  assign start  = accept && (wr_data != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (clr)    count_q <= '0;
    else if (accept) count_q <= wr_data;
  end
endmodule

// File: rtl/txl_out_stage.sv
module txl_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_last,
  input  logic [DATA_W-1:0] rd_data,
  output logic              can_issue,
  output logic              empty,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready
);
  logic              infl_q, infl_last_q;
  logic              skid_v;
  logic [DATA_W-1:0] skid_d;
  logic              skid_l;
  logic              pop, out_free;
  logic [1:0]        occ;

  assign pop      = out_valid && out_ready;
  assign out_free = !out_valid || pop;
  assign occ      = {1'b0, out_valid} + {1'b0, skid_v} + {1'b0, infl_q};
  // Room for one more returning byte after this cycle's pop.
  assign can_issue = (occ - {1'b0, pop}) < 2'd2;
  assign empty     = (occ == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      infl_q      <= 1'b0;
      infl_last_q <= 1'b0;
      skid_v      <= 1'b0;
      skid_d      <= '0;
      skid_l      <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_last    <= 1'b0;
    end else begin
      infl_q      <= issue;
      infl_last_q <= issue_last;
      if (out_free) begin
        if (skid_v) begin
          out_valid <= 1'b1;
          out_data  <= skid_d;
          out_last  <= skid_l;
          skid_v    <= infl_q;
          if (infl_q) begin
            skid_d <= rd_data;
            skid_l <= infl_last_q;
          end
        end else if (infl_q) begin
          out_valid <= 1'b1;
          out_data  <= rd_data;
          out_last  <= infl_last_q;
        end else begin
          out_valid <= 1'b0;
        end
      end else if (infl_q) begin
        skid_v <= 1'b1;
        skid_d <= rd_data;
        skid_l <= infl_last_q;
      end
    end
  end
endmodule

// File: rtl/txl_seq.sv
module txl_seq
  import txl_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 11,
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1530,
  parameter int HDR_LEN  = 8,
  parameter int TAIL_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_len,
  input  logic              can_issue,
  input  logic              stage_empty,
  input  logic [7:0]        rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              issue,
  output logic              issue_last,
  output logic              busy,
  output logic              irq,
  output logic              clr
);
  localparam int HDR_IW = $clog2(HDR_LEN);

  txl_state_e        state;
  logic [HDR_IW-1:0] hdr_idx, hdr_idx_q;
  logic              hdr_all, hdr_vld_q, bad;
  logic [ADDR_W-1:0] snd_addr, last_addr;
  logic              sent_all;
  logic              len_bad, hdr_miss, hdr_final;
  logic [7:0]        hdr_expect;

  assign len_bad    = (start_len < CNT_W'(MIN_LEN)) || (start_len > CNT_W'(MAX_LEN));
  assign hdr_final  = hdr_vld_q && (hdr_idx_q == HDR_IW'(HDR_LEN - 1));
  assign hdr_expect = (hdr_idx_q == HDR_IW'(HDR_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
  assign hdr_miss   = hdr_vld_q && (rd_data != hdr_expect);

  assign busy = (state != ST_IDLE);
  assign irq  = (state == ST_DONE);
  assign clr  = (state == ST_SEND) && sent_all && stage_empty;

  always_comb begin
    rd_en      = 1'b0;
    rd_addr    = '0;
    issue      = 1'b0;
    issue_last = 1'b0;
    case (state)
      ST_CHECK: if (!hdr_all) begin
        rd_en   = 1'b1;
        rd_addr = ADDR_W'(hdr_idx);
      end
      ST_SEND: if (!sent_all && can_issue) begin
        rd_en      = 1'b1;
        rd_addr    = snd_addr;
        issue      = 1'b1;
        issue_last = (snd_addr == last_addr);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hdr_idx   <= '0;
      hdr_idx_q <= '0;
      hdr_all   <= 1'b0;
      hdr_vld_q <= 1'b0;
      bad       <= 1'b0;
      snd_addr  <= '0;
      last_addr <= '0;
      sent_all  <= 1'b0;
    end else begin
      hdr_vld_q <= (state == ST_CHECK) && !hdr_all;
      hdr_idx_q <= hdr_idx;
      case (state)
        ST_IDLE: if (start) begin
          last_addr <= ADDR_W'(start_len - CNT_W'(TAIL_LEN + 1));
          hdr_idx   <= '0;
          hdr_all   <= 1'b0;
          bad       <= 1'b0;
          state     <= len_bad ? ST_DONE : ST_CHECK;
        end
        ST_CHECK: begin
          if (!hdr_all) begin
            hdr_idx <= hdr_idx + 1'b1;
            if (hdr_idx == HDR_IW'(HDR_LEN - 1)) hdr_all <= 1'b1;
          end
          if (hdr_miss) bad <= 1'b1;
          if (hdr_final) begin
            state    <= (bad || hdr_miss) ? ST_DONE : ST_SEND;
            snd_addr <= ADDR_W'(HDR_LEN);
            sent_all <= 1'b0;
          end
        end
        ST_SEND: begin
          if (issue) begin
            snd_addr <= snd_addr + 1'b1;
            if (issue_last) sent_all <= 1'b1;
          end
          if (clr) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_frame_launcher.sv
module tx_frame_launcher #(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1530,
  parameter int HDR_LEN  = 8,
  parameter int TAIL_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  output logic [CNT_W-1:0]  count_q,
  output logic              busy,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_rd_addr,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              done_irq
);
  logic start, clr, can_issue, stage_empty, issue, issue_last;

  txl_count_reg #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cnt_wr_en),
    .wr_data (cnt_wr_data),
    .busy    (busy),
    .clr     (clr),
    .count_q (count_q),
    .start   (start)
  );

  txl_seq #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .HDR_LEN(HDR_LEN), .TAIL_LEN(TAIL_LEN)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_len   (cnt_wr_data),
    .can_issue   (can_issue),
    .stage_empty (stage_empty),
    .rd_data     (buf_rd_data[7:0]),
    .rd_en       (buf_rd_en),
    .rd_addr     (buf_rd_addr),
    .issue       (issue),
    .issue_last  (issue_last),
    .busy        (busy),
    .irq         (done_irq),
    .clr         (clr)
  );

  txl_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_last (issue_last),
    .rd_data    (buf_rd_data),
    .can_issue  (can_issue),
    .empty      (stage_empty),
    .out_valid  (tx_valid),
    .out_data   (tx_data),
    .out_last   (tx_last),
    .out_ready  (tx_ready)
  );
endmodule

// File: rtl/txl_checker.sv
module txl_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_wr_en,
  input logic [CNT_W-1:0]  cnt_wr_data,
  input logic [CNT_W-1:0]  count_q,
  input logic              busy,
  input logic              buf_rd_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_last,
  input logic              done_irq
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cnt_wr_en && cnt_wr_data != '0) |=> busy);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_valid && !buf_rd_en));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_pulse_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (busy && !tx_valid));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_wr_en) |=> (count_q == $past(count_q) || count_q == '0));
endmodule

bind tx_frame_launcher txl_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_txl_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .count_q     (count_q),
  .busy        (busy),
  .buf_rd_en   (buf_rd_en),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .tx_last     (tx_last),
  .done_irq    (done_irq)
);

// File: tb/tx_frame_launcher_test.sv
module tx_frame_launcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_wr_en = 1'b0;
  logic [15:0] cnt_wr_data = '0;
  logic [15:0] count_q;
  logic        busy, buf_rd_en, tx_valid, tx_last, done_irq;
  logic [10:0] buf_rd_addr;
  logic [7:0]  buf_rd_data = '0;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [2048];

  // run_frame results
  int         got_bytes, irq_seen, last_count, data_err, stab_err;
  logic [15:0] cnt_at_irq;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];

  tx_frame_launcher uut (
    .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .count_q(count_q), .busy(busy), .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
    .buf_rd_data(buf_rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .done_irq(done_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_image(input int seed);
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 7 + seed * 13 + 3) ^ (i >> 3));
    for (int i = 0; i < 7; i++) mem[i] = 8'h55;
    mem[7] = 8'hD5;
  endtask

  task automatic write_count(input logic [15:0] v);
    @(negedge clk);
    cnt_wr_en = 1'b1; cnt_wr_data = v;
    @(negedge clk);
    cnt_wr_en = 1'b0; cnt_wr_data = '0;
  endtask

  // Launch and observe until the completion pulse plus a few quiet cycles.
  // mode 0: always ready; mode 1: stall pattern; mode 2: long stall at start
  task automatic run_frame(input logic [15:0] len, input int mode, input logic [15:0] mid_write);
    int cyc = 0, post = -1;
    logic pv = 0, pr = 0, pl = 0; logic [7:0] pd = 0;
    got_bytes = 0; irq_seen = 0; last_count = 0; data_err = 0; stab_err = 0; cnt_at_irq = '0;
    write_count(len);
    check(busy == 1'b1 || len == 0, "R1 busy after launch", int'(busy), 1);
    while (post != 0 && cyc < 20000) begin
      case (mode)
        1: tx_ready = ((cyc % 5) != 1) && ((cyc % 7) != 3);
        2: tx_ready = (cyc > 60) && ((cyc % 3) != 0);
        default: tx_ready = 1'b1;
      endcase
      if (pv && !pr && !(tx_valid && tx_data == pd && tx_last == pl)) stab_err++;
      if (tx_valid && tx_ready) begin
        if (tx_data != mem[8 + got_bytes]) data_err++;
        if (tx_last) last_count++;
        if (tx_last != (got_bytes == int'(len) - 13)) data_err++;
        got_bytes++;
      end
      if (done_irq) begin irq_seen++; cnt_at_irq = count_q; if (post < 0) post = 4; end
      pv = tx_valid; pr = tx_ready; pd = tx_data; pl = tx_last;
      if (mid_write != 0 && cyc == 30) begin
        cnt_wr_en = 1'b1; cnt_wr_data = mid_write;
        @(negedge clk);
        cnt_wr_en = 1'b0;
        check(count_q == len, "R10 count unchanged by busy write", int'(count_q), int'(len));
        cyc++;
        continue;
      end
      @(negedge clk);
      cyc++;
      if (post > 0) post--;
    end
    tx_ready = 1'b1;
  endtask

  task automatic t_reset;
    check(busy == 0, "R11 busy", int'(busy), 0);
    check(tx_valid == 0, "R11 tx_valid", int'(tx_valid), 0);
    check(done_irq == 0, "R11 done_irq", int'(done_irq), 0);
    check(count_q == 0, "R11 count_q", int'(count_q), 0);
  endtask

  task automatic t_short;
    load_image(1);
    run_frame(16'd63, 0, 0);
    check(got_bytes == 0, "R2 no bytes for 63", got_bytes, 0);
    check(irq_seen == 1, "R2/R9 one pulse", irq_seen, 1);
    check(cnt_at_irq == 63, "R8 count kept on reject", int'(cnt_at_irq), 63);
  endtask

  task automatic t_zero_write;
    int irqs = 0;
    write_count(16'd0);
    check(busy == 0, "R1 zero write no start", int'(busy), 0);
    check(count_q == 0, "R1 zero stored", int'(count_q), 0);
    repeat (20) begin @(negedge clk); if (done_irq) irqs++; end
    check(irqs == 0, "R1 zero write no pulse", irqs, 0);
  endtask

  task automatic t_long;
    load_image(2);
    run_frame(16'd1531, 0, 0);
    check(got_bytes == 0, "R3 no bytes for 1531", got_bytes, 0);
    check(irq_seen == 1, "R3/R9 one pulse", irq_seen, 1);
    check(cnt_at_irq == 1531, "R8 count kept", int'(cnt_at_irq), 1531);
  endtask

  task automatic t_bad_hdr(input int pos, input logic [7:0] v);
    load_image(3);
    mem[pos] = v;
    run_frame(16'd100, 0, 0);
    check(got_bytes == 0, "R4 bad header no bytes", got_bytes, 0);
    check(irq_seen == 1, "R4/R9 one pulse", irq_seen, 1);
    check(cnt_at_irq == 100, "R8 count kept on header reject", int'(cnt_at_irq), 100);
  endtask

  task automatic t_good(input logic [15:0] len, input int mode, input int seed);
    load_image(seed);
    run_frame(len, mode, 0);
    check(got_bytes == int'(len) - 12, "R5 byte count", got_bytes, int'(len) - 12);
    check(data_err == 0, "R5/R6 data order and last", data_err, 0);
    check(last_count == 1, "R6 single last", last_count, 1);
    check(stab_err == 0, "R7 hold under stall", stab_err, 0);
    check(irq_seen == 1, "R9 one pulse", irq_seen, 1);
    check(cnt_at_irq == 0, "R8 cleared on success", int'(cnt_at_irq), 0);
  endtask

  task automatic t_busy_write;
    load_image(9);
    run_frame(16'd100, 2, 16'd70);
    check(got_bytes == 88, "R10 original frame length", got_bytes, 88);
    check(irq_seen == 1, "R10 no second attempt", irq_seen, 1);
    check(data_err == 0, "R5 data under busy write", data_err, 0);
    check(busy == 0, "R10 idle afterwards", int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_zero_write();
    t_long();
    t_bad_hdr(3, 8'h54);
    t_bad_hdr(7, 8'h55);
    t_bad_hdr(0, 8'hD5);
    t_good(16'd64, 0, 4);
    t_good(16'd200, 1, 5);
    t_good(16'd1530, 1, 6);
    t_good(16'd97, 2, 7);
    t_busy_write();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule